// File: doc/BRIEF.md
# HDLC Station Address Filter

This block sits between an HDLC receiver's byte output and the receive queue. It decides, once per frame, whether the frame is meant for this station. It does this by comparing the leading one or two address bytes against two programmed reference bytes. The extension bit, bit 0 of the first received byte, sets the address length. An all-ones address acts as a broadcast and is always taken. When the frame is single-byte, a control bit widens the first-byte compare from six to seven bits.

Bytes arrive with a valid strobe. The first byte of a frame carries a start marker and the last byte carries an end marker. The filter holds the first byte until it has made a decision, so no byte of a frame reaches the output before the verdict. An accepted frame passes through complete and in order, with its end marker. A rejected frame produces nothing at all on the output. A one-cycle decision strobe reports the verdict for each frame. The verdict is given on the second byte, or on the only byte of a one-byte frame.

Top module: `hdlc_addr_filter`

## Requirements
- R1: When `cfg_recog_en` is 0, every frame is accepted, whatever its address bytes are.
- R2: If bit 0 of the first byte is 1, the address is one byte long. With `cfg_en1`=1, the frame is accepted when bits 7..2 of that byte equal bits 7..2 of `cfg_addr1`. When `cfg_seven`=1, bits 7..1 are compared instead.
- R3: For a one-byte address, `cfg_en1`=0 accepts the frame without any compare.
- R4: For a one-byte address, the frame is accepted when the compared bits of the first byte are all ones. This is bits 7..2, or bits 7..1 when `cfg_seven`=1.
- R5: For a one-byte address, the value of the second byte has no effect on the verdict.
- R6: If bit 0 of the first byte is 0, the address is two bytes long. The first-byte check passes when `cfg_en1`=0, or when bits 7..2 equal those of `cfg_addr1`. The second-byte check passes when `cfg_en2`=0, or when bits 7..1 equal those of `cfg_addr2`. The frame is accepted when both checks pass.
- R7: For a two-byte address, bits 7..1 of the second byte all set to one accept the frame, whatever the first byte and the enables are.
- R8: For a two-byte address, `cfg_seven` has no effect on the verdict.
- R9: An accepted frame is sent out on `out_valid`/`out_data` byte for byte, in order, with `out_eof` high on its last byte only. A rejected frame produces no output byte.
- R10: `dec_valid` pulses exactly once per frame: with the second byte, or with the byte of a one-byte frame. A one-byte frame with bit 0 equal to 0 is rejected while recognition is enabled.
- R11: Bytes that arrive without a start marker while no frame is open are dropped and produce no output and no verdict.
- R12: While reset is held, and right after it, `out_valid`, `out_eof` and `dec_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Received byte present |
| in_data | input | BW | Received byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| cfg_recog_en | input | 1 | Enable address filtering |
| cfg_en1 | input | 1 | Compare the first address byte |
| cfg_en2 | input | 1 | Compare the second address byte |
| cfg_seven | input | 1 | Seven-bit compare for one-byte addresses |
| cfg_addr1 | input | BW | Reference for the first address byte |
| cfg_addr2 | input | BW | Reference for the second address byte |
| out_valid | output | 1 | Forwarded byte present |
| out_data | output | BW | Forwarded byte |
| out_eof | output | 1 | Forwarded byte ends the frame |
| dec_valid | output | 1 | Verdict strobe, one per frame |
| dec_accept | output | 1 | Verdict: 1 accept, 0 reject |

## Verification
The bench builds the filter with its default byte width of 8, so the extension bit, the six- and seven-bit fields and the all-call patterns sit at their real positions. At this width a random byte matches a reference rarely. The stimulus therefore copies the reference bytes, or flips one bit of them, and plants all-ones values on purpose. That puts matches, near misses and broadcasts all within reach. Frames of one to six bytes are sent with zero-cycle and longer gaps between bytes and between frames. These exercise one-byte verdicts and back-to-back frames, where a new start marker meets a pending end byte.

// File: rtl/hafl_pkg.sv
package hafl_pkg;
  // number of leading bytes that can take part in the address decision
  localparam int unsigned ADDR_BYTES = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // waiting for a start marker
    ST_ADDR2 = 2'd1,  // first byte held, waiting for the second
    ST_PASS  = 2'd2,  // frame accepted, bytes stream through
    ST_DROP  = 2'd3   // frame rejected, bytes swallowed until the end
  } hafl_state_e;
endpackage

// File: rtl/hafl_match.sv
module hafl_match #(
  parameter int BW = 8
) (
  input  logic          recog_en,
  input  logic          en1,
  input  logic          en2,
  input  logic          seven,
  input  logic [BW-1:0] ref1,
  input  logic [BW-1:0] ref2,
  input  logic [BW-1:0] b1,
  input  logic [BW-1:0] b2,
  input  logic          have_b2,
  output logic          accept,
  output logic          single,
  output logic          allcall1,
  output logic          allcall2
);
  import hafl_pkg::*;

  // field masks: the low bits carry the extension and command bits
  localparam logic [BW-1:0] MASK_SIX   = {{(BW-2){1'b1}}, 2'b00};
  localparam logic [BW-1:0] MASK_SEVEN = {{(BW-1){1'b1}}, 1'b0};

  function automatic logic field_hit(input logic [BW-1:0] rx,
                                     input logic [BW-1:0] rf,
                                     input logic [BW-1:0] m);
    return ((rx ^ rf) & m) == '0;
  endfunction

  function automatic logic field_all(input logic [BW-1:0] rx,
                                     input logic [BW-1:0] m);
    return (rx & m) == m;
  endfunction

  logic [BW-1:0] rx_v  [ADDR_BYTES];
  logic [BW-1:0] ref_v [ADDR_BYTES];
  logic [BW-1:0] msk_v [ADDR_BYTES];
  logic [ADDR_BYTES-1:0] en_v, hit_v, all_v, pass_v;

  assign single   = b1[0];
  assign rx_v[0]  = b1;
  assign rx_v[1]  = b2;
  assign ref_v[0] = ref1;
  assign ref_v[1] = ref2;
  assign en_v     = {en2, en1};
  // seven-bit first-byte compare only applies to one-byte addresses
  assign msk_v[0] = (single && seven) ? MASK_SEVEN : MASK_SIX;
  assign msk_v[1] = MASK_SEVEN;

  for (genvar gi = 0; gi < ADDR_BYTES; gi++) begin : g_byte
    assign hit_v[gi]  = field_hit(rx_v[gi], ref_v[gi], msk_v[gi]);
    assign all_v[gi]  = field_all(rx_v[gi], msk_v[gi]);
    assign pass_v[gi] = !en_v[gi] || hit_v[gi];
  end

  assign allcall1 = all_v[0];
  assign allcall2 = all_v[1];

  always_comb begin
    if (!recog_en)     accept = 1'b1;
    else if (single)   accept = all_v[0] || pass_v[0];
    else if (!have_b2) accept = 1'b0;
    else               accept = all_v[1] || (pass_v[0] && pass_v[1]);
  end
endmodule

// File: rtl/hafl_flow.sv
module hafl_flow #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [BW-1:0] in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic          accept,
  output logic [BW-1:0] cmp_b1,
  output logic [BW-1:0] cmp_b2,
  output logic          cmp_have_b2,
  output logic          decide,
  output logic          emit,
  output logic          in_pass,
  output logic          out_valid,
  output logic [BW-1:0] out_data,
  output logic          out_eof,
  output logic          dec_valid,
  output logic          dec_accept
);
  import hafl_pkg::*;

  hafl_state_e   state;
  logic          p_vld, p_eof;
  logic [BW-1:0] p_data;
  logic          start, second, emit_pend, emit_first;

  always_comb begin
    start       = in_valid && in_sof;
    second      = in_valid && !in_sof && (state == ST_ADDR2);
    decide      = (start && in_eof) || second;
    emit_pend   = (state == ST_PASS) && p_vld;
    emit_first  = second && accept;
    emit        = emit_pend || emit_first;
    in_pass     = (state == ST_PASS);
    cmp_b1      = start ? in_data : p_data;
    cmp_b2      = in_data;
    cmp_have_b2 = second;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      p_vld      <= 1'b0;
      p_eof      <= 1'b0;
      p_data     <= '0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_eof    <= 1'b0;
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      out_valid  <= emit;
      out_eof    <= emit && p_eof;
      if (emit) out_data <= p_data;
      dec_valid  <= decide;
      dec_accept <= decide && accept;

      if (start) begin
        p_data <= in_data;
        if (in_eof) begin
          p_vld <= accept;
          p_eof <= 1'b1;
          state <= accept ? ST_PASS : ST_IDLE;
        end else begin
          p_vld <= 1'b1;
          p_eof <= 1'b0;
          state <= ST_ADDR2;
        end
      end else if (second) begin
        if (accept) begin
          p_vld  <= 1'b1;
          p_data <= in_data;
          p_eof  <= in_eof;
          state  <= ST_PASS;
        end else begin
          p_vld <= 1'b0;
          p_eof <= 1'b0;
          state <= in_eof ? ST_IDLE : ST_DROP;
        end
      end else begin
        case (state)
          ST_PASS: begin
            if (p_vld && p_eof) begin
              p_vld <= 1'b0;
              p_eof <= 1'b0;
              state <= ST_IDLE;
            end else if (in_valid) begin
              p_vld  <= 1'b1;
              p_data <= in_data;
              p_eof  <= in_eof;
            end else begin
              p_vld <= 1'b0;
            end
          end
          ST_DROP: begin
            p_vld <= 1'b0;
            if (in_valid && in_eof) state <= ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [BW-1:0] in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic          cfg_recog_en,
  input  logic          cfg_en1,
  input  logic          cfg_en2,
  input  logic          cfg_seven,
  input  logic [BW-1:0] cfg_addr1,
  input  logic [BW-1:0] cfg_addr2,
  output logic          out_valid,
  output logic [BW-1:0] out_data,
  output logic          out_eof,
  output logic          dec_valid,
  output logic          dec_accept
);
  // named internal events, brought out for the checker
  logic [BW-1:0] w_b1, w_b2;
  logic          w_have_b2, w_accept, w_single, w_allcall1, w_allcall2;
  logic          w_decide, w_emit, w_pass;

  hafl_match #(.BW(BW)) u_match (
    .recog_en (cfg_recog_en),
    .en1      (cfg_en1),
    .en2      (cfg_en2),
    .seven    (cfg_seven),
    .ref1     (cfg_addr1),
    .ref2     (cfg_addr2),
    .b1       (w_b1),
    .b2       (w_b2),
    .have_b2  (w_have_b2),
    .accept   (w_accept),
    .single   (w_single),
    .allcall1 (w_allcall1),
    .allcall2 (w_allcall2)
  );

  hafl_flow #(.BW(BW)) u_flow (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_sof      (in_sof),
    .in_eof      (in_eof),
    .accept      (w_accept),
    .cmp_b1      (w_b1),
    .cmp_b2      (w_b2),
    .cmp_have_b2 (w_have_b2),
    .decide      (w_decide),
    .emit        (w_emit),
    .in_pass     (w_pass),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_eof     (out_eof),
    .dec_valid   (dec_valid),
    .dec_accept  (dec_accept)
  );
endmodule

// File: rtl/hafl_chk.sv
module hafl_chk #(
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_recog_en,
  input logic          w_decide,
  input logic          w_accept,
  input logic          w_single,
  input logic          w_have_b2,
  input logic          w_allcall1,
  input logic          w_allcall2,
  input logic          w_emit,
  input logic          w_pass,
  input logic          out_valid,
  input logic [BW-1:0] out_data,
  input logic          out_eof,
  input logic          dec_valid,
  input logic          dec_accept
);
  p_open_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (w_decide && !cfg_recog_en) |-> w_accept);

  p_single_allcall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (w_decide && cfg_recog_en && w_single && w_allcall1) |=> dec_accept);

  p_pair_allcall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (w_decide && cfg_recog_en && !w_single && w_have_b2 && w_allcall2) |=> dec_accept);

  p_reject_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_accept) |=> !out_valid);

  p_emit_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    w_emit |-> (w_pass || (w_accept && w_have_b2)));

  p_eof_with_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> out_valid);

  p_data_known_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown(out_data));
endmodule

bind hdlc_addr_filter hafl_chk #(.BW(BW)) u_hafl_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_recog_en (cfg_recog_en),
  .w_decide     (w_decide),
  .w_accept     (w_accept),
  .w_single     (w_single),
  .w_have_b2    (w_have_b2),
  .w_allcall1   (w_allcall1),
  .w_allcall2   (w_allcall2),
  .w_emit       (w_emit),
  .w_pass       (w_pass),
  .out_valid    (out_valid),
  .out_data     (out_data),
  .out_eof      (out_eof),
  .dec_valid    (dec_valid),
  .dec_accept   (dec_accept)
);

// File: tb/test_hdlc_addr_filter.sv
module test_hdlc_addr_filter;
  localparam int BW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic cfg_recog_en = 1'b0, cfg_en1 = 1'b0, cfg_en2 = 1'b0, cfg_seven = 1'b0;
  logic [7:0] cfg_addr1 = 8'h00, cfg_addr2 = 8'h00;
  logic out_valid, out_eof, dec_valid, dec_accept;
  logic [7:0] out_data;

  always #5 clk = ~clk;

  hdlc_addr_filter #(.BW(BW)) i_hdlc_addr_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .cfg_recog_en(cfg_recog_en),
    .cfg_en1(cfg_en1), .cfg_en2(cfg_en2), .cfg_seven(cfg_seven),
    .cfg_addr1(cfg_addr1), .cfg_addr2(cfg_addr2), .out_valid(out_valid),
    .out_data(out_data), .out_eof(out_eof), .dec_valid(dec_valid),
    .dec_accept(dec_accept)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // expected streams
  logic [8:0] exp_byte [0:4095];
  logic       exp_dec  [0:1023];
  string      exp_tag  [0:1023];
  int bw_ptr = 0, br_ptr = 0, dw_ptr = 0, dr_ptr = 0;
  string force_tag = "";
  logic [7:0] fr [0:7];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // verdict restated from the requirements with explicit bit slices
  function automatic bit want_accept(input bit rec, input bit e1, input bit e2,
      input bit sev, input logic [7:0] a1, input logic [7:0] a2,
      input logic [7:0] x1, input logic [7:0] x2, input bit two);
    bit ok1, ok2;
    if (!rec) return 1;
    if (x1[0]) begin
      if (sev) return (&x1[7:1]) || !e1 || (x1[7:1] == a1[7:1]);
      return (&x1[7:2]) || !e1 || (x1[7:2] == a1[7:2]);
    end
    if (!two) return 0;
    if (&x2[7:1]) return 1;
    ok1 = !e1 || (x1[7:2] == a1[7:2]);
    ok2 = !e2 || (x2[7:1] == a2[7:1]);
    return ok1 && ok2;
  endfunction

  function automatic string pick_tag(input int len);
    if (force_tag != "") return force_tag;
    if (!cfg_recog_en) return "R1";
    if (fr[0][0]) begin
      if (!cfg_en1) return "R3";
      if (cfg_seven ? (&fr[0][7:1]) : (&fr[0][7:2])) return "R4";
      return "R2";
    end
    if (len == 1) return "R10";
    if (&fr[1][7:1]) return "R7";
    return "R6";
  endfunction

  task automatic put_byte(input logic [7:0] d, input logic s, input logic e);
    in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic send_frame(input int len, input int maxgap);
    bit acc;
    acc = want_accept(cfg_recog_en, cfg_en1, cfg_en2, cfg_seven, cfg_addr1,
                      cfg_addr2, fr[0], fr[1], len > 1);
    exp_dec[dw_ptr] = acc;
    exp_tag[dw_ptr] = pick_tag(len);
    dw_ptr++;
    if (acc)
      for (int k = 0; k < len; k++) begin
        exp_byte[bw_ptr] = {k == len - 1, fr[k]};
        bw_ptr++;
      end
    for (int k = 0; k < len; k++) begin
      put_byte(fr[k], k == 0, k == len - 1);
      if (maxgap > 0) repeat ($urandom_range(maxgap, 0)) @(negedge clk);
    end
  endtask

  // monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (dec_valid) begin
        if (dr_ptr >= dw_ptr)
          check(0, "R10", "unexpected verdict", 1, 0);
        else begin
          check(dec_accept == exp_dec[dr_ptr], exp_tag[dr_ptr], "verdict",
                dec_accept, exp_dec[dr_ptr]);
          dr_ptr++;
        end
      end
      if (out_valid) begin
        if (br_ptr >= bw_ptr)
          check(0, "R9", "unexpected output byte", {out_eof, out_data}, 0);
        else begin
          check({out_eof, out_data} == exp_byte[br_ptr], "R9", "output byte",
                {out_eof, out_data}, exp_byte[br_ptr]);
          br_ptr++;
        end
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog R9: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  task automatic set_cfg(input bit rec, input bit e1, input bit e2, input bit sev,
                         input logic [7:0] a1, input logic [7:0] a2);
    cfg_recog_en = rec; cfg_en1 = e1; cfg_en2 = e2; cfg_seven = sev;
    cfg_addr1 = a1; cfg_addr2 = a2;
  endtask

  initial begin
    int pb, pd;
    void'($urandom(32'd20251));
    repeat (3) @(negedge clk);
    // R12: reset state
    check(out_valid == 0 && out_eof == 0 && dec_valid == 0, "R12",
          "outputs in reset", {out_valid, out_eof, dec_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 0 && dec_valid == 0, "R12", "outputs after reset",
          {out_valid, dec_valid}, 0);

    // R1: filter off, mismatching address still passes
    set_cfg(0, 1, 1, 0, 8'h40, 8'h22);
    fr[0] = 8'h11; fr[1] = 8'h99; fr[2] = 8'h5A;
    send_frame(3, 0);

    // R5: one-byte address, second byte changes, verdict stays
    set_cfg(1, 1, 1, 0, 8'h45, 8'h00);
    force_tag = "R5";
    fr[0] = 8'h45; fr[1] = 8'h00; fr[2] = 8'h01; send_frame(3, 0);
    fr[0] = 8'h45; fr[1] = 8'hFF; fr[2] = 8'h01; send_frame(3, 1);
    fr[0] = 8'h41; fr[1] = 8'h45; fr[2] = 8'h01; send_frame(3, 0);
    fr[0] = 8'h41; fr[1] = 8'hFE; fr[2] = 8'h01; send_frame(3, 2);

    // R2: seven-bit mode separates values differing in bit 1
    set_cfg(1, 1, 0, 1, 8'h47, 8'h00);
    force_tag = "R2";
    fr[0] = 8'h45; fr[1] = 8'h10; send_frame(2, 0);   // bit 1 differs: reject
    fr[0] = 8'h47; fr[1] = 8'h10; send_frame(2, 0);   // accept
    cfg_seven = 0;
    fr[0] = 8'h45; fr[1] = 8'h10; send_frame(2, 0);   // six bits: accept

    // R8: seven-bit bit has no effect on two-byte addresses
    set_cfg(1, 1, 1, 1, 8'h44, 8'h31);
    force_tag = "R8";
    fr[0] = 8'h46; fr[1] = 8'h31; fr[2] = 8'hC3; send_frame(3, 0); // accept
    cfg_seven = 0;
    fr[0] = 8'h46; fr[1] = 8'h31; fr[2] = 8'hC3; send_frame(3, 0); // accept
    fr[0] = 8'h48; fr[1] = 8'h31; send_frame(2, 0);                // reject

    // R10: one-byte frame with two-byte extension bit is rejected
    force_tag = "R10";
    fr[0] = 8'h44; send_frame(1, 0);
    force_tag = "";

    // R11: stray bytes without a start marker
    repeat (4) @(negedge clk);
    pb = br_ptr; pd = dr_ptr;
    put_byte(8'h45, 0, 0);
    put_byte(8'hFF, 0, 1);
    put_byte(8'h12, 0, 0);
    repeat (4) @(negedge clk);
    check(br_ptr == pb && dr_ptr == pd, "R11", "stray bytes ignored",
          br_ptr - pb + dr_ptr - pd, 0);

    // random frames, back-to-back and with gaps
    for (int n = 0; n < 400; n++) begin
      int len, sel;
      set_cfg($urandom_range(3, 0) != 0, $urandom_range(1, 0), $urandom_range(1, 0),
              $urandom_range(1, 0), 8'($urandom), 8'($urandom));
      len = $urandom_range(6, 1);
      for (int k = 0; k < 8; k++) fr[k] = 8'($urandom);
      sel = $urandom_range(5, 0);
      if (sel < 2) fr[0] = cfg_addr1 ^ ((sel == 1) ? (8'h01 << $urandom_range(7, 0)) : 8'h00);
      else if (sel == 2) fr[0] = 8'hFE | 8'($urandom_range(1, 0));
      else if (sel == 3) fr[0][1:0] = 2'b11 & 2'($urandom);
      sel = $urandom_range(5, 0);
      if (sel < 2) fr[1] = cfg_addr2 ^ ((sel == 1) ? (8'h01 << $urandom_range(7, 0)) : 8'h00);
      else if (sel == 2) fr[1] = 8'hFE | 8'($urandom_range(1, 0));
      send_frame(len, $urandom_range(2, 0));
      repeat ($urandom_range(3, 0)) @(negedge clk);
    end

    repeat (10) @(negedge clk);
    check(br_ptr == bw_ptr, "R9", "all accepted bytes delivered", br_ptr, bw_ptr);
    check(dr_ptr == dw_ptr, "R10", "one verdict per frame", dr_ptr, dw_ptr);
    done = 1;
    summary();
    $finish;
  end
endmodule